// File: doc/BRIEF.md
# Prescaled Timer with Match and Capture Channels

This block is a free-running up-counter for general timing work. A programmable prescaler divides the clock: the prescale counter climbs to a limit, wraps to zero and advances the main count by one. Four match channels watch the count. On a hit, each channel can flag an interrupt, send the count back to zero, or halt counting, in any mix. Each match channel also drives its own output pin. On a hit that pin can keep its level, go low, go high or flip.

Four capture channels watch external inputs. Each one takes a copy of the count on a rising edge, a falling edge or both, as configured, and can flag an interrupt. All state is reached through a plain register bus: a write strobe with address and data, and read data that is a direct function of the address. There is no streaming data path, so no valid/ready handshake appears at the edge. Writes complete in the cycle they are presented, and there is no back-pressure.

The register map uses word addresses:

| Address | Contents |
|---|---|
| 0 | Control: bit 0 run, bit 1 clear-and-hold |
| 1 | Count |
| 2 | Prescale limit |
| 3 | Prescale counter |
| 4 | Flags |
| 5 | Match actions |
| 6 | Capture configuration |
| 7 | Pin actions and pin levels |
| 8 to 11 | Match values for channels 0 to 3 |
| 12 to 15 | Captured values for channels 0 to 3, read-only |

Top module: `tmr_match_capture`

## Requirements
- R1: After reset every register reads zero, all four pins are low and `irq` is low.
- R2: While run is set and clear-and-hold is not, the prescale counter rises by one each cycle. In the cycle it equals the prescale limit, a tick occurs: the prescale counter wraps to 0 and the count rises by one. The count therefore advances once every limit+1 cycles.
- R3: While clear-and-hold (control bit 1) is set, both the count and the prescale counter are held at zero. While run is clear, neither counter moves.
- R4: A match hit for channel k happens on a tick when the count equals match value k. If action bit 3k (interrupt) is set, the hit sets flag bit k. `irq` is the OR of all flag bits.
- R5: A hit on a channel with action bit 3k+1 (reset) set makes the count become 0 at that tick instead of count+1.
- R6: A hit on a channel with action bit 3k+2 (stop) set clears run and suppresses the increment. If reset is also requested in that tick, the count becomes 0 and run still clears. Stop overrides a same-cycle write to run.
- R7: Pin action field k sits at register 7 bits [2k+1:2k] and is applied on each hit of channel k. The codes are: 0 keep the level, 1 drive low, 2 drive high, 3 toggle. A write to register 7 also loads the pin levels from bits [11:8].
- R8: Capture configuration bit 3k enables rising edges and bit 3k+1 enables falling edges of `cap_in[k]`. On an enabled edge, capture register k takes the count value held before that clock edge. With both bits clear the input has no effect.
- R9: Capture configuration bit 3k+2 makes an enabled capture edge set flag bit 4+k.
- R10: Writing a one to a flag bit clears it and writing zero leaves it. A flag set in the same cycle as its clear stays set.
- R11: A bus write to count, prescale limit, prescale counter, action, configuration or match registers takes effect at the next clock edge and reads back unchanged. A write to count or to the prescale counter overrides counting in that cycle.
- R12: A match is evaluated only on ticks, so a count that rests on a match value across several prescaled cycles fires that channel once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| cap_in | input | 4 | Capture inputs, synchronous to `clk` |
| mat_out | output | 4 | Match-driven output pins |
| irq | output | 1 | OR of all flags |

## Verification
The hardest situations to reach are the coincidences inside a single tick. One is a stop and a reset landing together. Another is a flag being cleared by software in the very cycle that a hit sets it again. The stimulus drives the prescale limit to zero so that every cycle is a tick. It uses a short reset period on one channel so that hits recur every few cycles, then writes flag clears on consecutive cycles so that some clears coincide with sets. A behavioural model in the bench predicts every register, pin and `irq` on every clock, so these collisions are checked in whichever cycle they happen.

// File: rtl/tmc_pkg.sv
package tmc_pkg;
  localparam int unsigned TMC_CH = 4;
  localparam int unsigned TMC_AW = 4;

  localparam logic [TMC_AW-1:0] A_CTRL  = 4'd0;
  localparam logic [TMC_AW-1:0] A_COUNT = 4'd1;
  localparam logic [TMC_AW-1:0] A_PLIM  = 4'd2;
  localparam logic [TMC_AW-1:0] A_PCNT  = 4'd3;
  localparam logic [TMC_AW-1:0] A_FLAGS = 4'd4;
  localparam logic [TMC_AW-1:0] A_MACT  = 4'd5;
  localparam logic [TMC_AW-1:0] A_CCFG  = 4'd6;
  localparam logic [TMC_AW-1:0] A_OCFG  = 4'd7;
  localparam logic [TMC_AW-1:0] A_MBASE = 4'd8;
  localparam logic [TMC_AW-1:0] A_CBASE = 4'd12;

  typedef enum logic [1:0] {OUT_KEEP, OUT_LOW, OUT_HIGH, OUT_TOGGLE} out_act_e;

  typedef struct packed {
    logic stop;
    logic rst;
    logic irq;
  } mact_t;

  typedef struct packed {
    logic irq;
    logic fall;
    logic rise;
  } ccfg_t;
endpackage

// File: rtl/tmc_prescaler.sv
module tmc_prescaler #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         hold,
  input  logic [W-1:0] limit,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] pcount,
  output logic         tick
);
  assign tick = en && !hold && (pcount == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pcount <= '0;
    else if (wr_en)  pcount <= wr_data;
    else if (hold)   pcount <= '0;
    else if (en)     pcount <= tick ? '0 : pcount + 1'b1;
  end

  AST_PRESC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en) |=> (pcount == '0)); // R2
endmodule

// File: rtl/tmc_match_chan.sv
module tmc_match_chan
  import tmc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [W-1:0] count,
  input  logic [W-1:0] match_val,
  input  mact_t        act,
  input  logic [1:0]   ocode,
  input  logic         pin_wr,
  input  logic         pin_wdata,
  output logic         want_rst,
  output logic         want_stop,
  output logic         flag_set,
  output logic         pin
);
  logic hit;

  assign hit       = tick && (count == match_val);
  assign want_rst  = hit && act.rst;
  assign want_stop = hit && act.stop;
  assign flag_set  = hit && act.irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pin <= 1'b0;
    else if (pin_wr) pin <= pin_wdata;
    else if (hit) begin
      case (ocode)
        OUT_LOW:    pin <= 1'b0;
        OUT_HIGH:   pin <= 1'b1;
        OUT_TOGGLE: pin <= ~pin;
        default:    pin <= pin;
      endcase
    end
  end

  AST_PIN_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ocode == OUT_TOGGLE && !pin_wr) |=> (pin != $past(pin))); // R7
  AST_PIN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!pin_wr && (!hit || ocode == OUT_KEEP)) |=> $stable(pin)); // R7
endmodule

// File: rtl/tmc_capture_chan.sv
module tmc_capture_chan
  import tmc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sig,
  input  logic [W-1:0] count,
  input  ccfg_t        cfg,
  output logic         flag_set,
  output logic [W-1:0] cap_val
);
  logic sig_q;
  logic evt;

  assign evt      = (cfg.rise && sig && !sig_q) || (cfg.fall && !sig && sig_q);
  assign flag_set = evt && cfg.irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_q   <= 1'b0;
      cap_val <= '0;
    end else begin
      sig_q <= sig;
      if (evt) cap_val <= count;
    end
  end

  AST_CAP_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> (cap_val == $past(count))); // R8
  AST_CAP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !evt |=> $stable(cap_val)); // R8
endmodule

// File: rtl/tmr_match_capture.sv
module tmr_match_capture
  import tmc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [TMC_AW-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic [TMC_CH-1:0] cap_in,
  output logic [TMC_CH-1:0] mat_out,
  output logic              irq
);
  localparam int N  = TMC_CH;
  localparam int IW = $clog2(N);
  localparam int FW = 2 * N;

  logic             wr_ctrl, wr_count, wr_plim, wr_pcnt, wr_flags, wr_mact, wr_ccfg, wr_ocfg;
  logic             run_q, clr_q, tick;
  logic [CNT_W-1:0] tc_q, lim_q, pcnt;
  logic [FW-1:0]    flags_q, set_vec, clr_mask;
  logic [3*N-1:0]   mact_q, ccfg_q;
  logic [2*N-1:0]   ocfg_q;
  logic [CNT_W-1:0] mreg_q [N];
  logic [CNT_W-1:0] cap_val [N];
  logic [N-1:0]     rst_v, stop_v, mset_v, cset_v;
  logic [IW-1:0]    sub;

  assign wr_ctrl  = bus_we && bus_addr == A_CTRL;
  assign wr_count = bus_we && bus_addr == A_COUNT;
  assign wr_plim  = bus_we && bus_addr == A_PLIM;
  assign wr_pcnt  = bus_we && bus_addr == A_PCNT;
  assign wr_flags = bus_we && bus_addr == A_FLAGS;
  assign wr_mact  = bus_we && bus_addr == A_MACT;
  assign wr_ccfg  = bus_we && bus_addr == A_CCFG;
  assign wr_ocfg  = bus_we && bus_addr == A_OCFG;

  tmc_prescaler #(.W(CNT_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .en(run_q), .hold(clr_q), .limit(lim_q),
    .wr_en(wr_pcnt), .wr_data(bus_wdata), .pcount(pcnt), .tick(tick)
  );

  for (genvar k = 0; k < N; k++) begin : g_ch
    tmc_match_chan #(.W(CNT_W)) u_match (
      .clk(clk), .rst_n(rst_n), .tick(tick), .count(tc_q), .match_val(mreg_q[k]),
      .act(mact_q[3*k +: 3]), .ocode(ocfg_q[2*k +: 2]),
      .pin_wr(wr_ocfg), .pin_wdata(bus_wdata[FW + k]),
      .want_rst(rst_v[k]), .want_stop(stop_v[k]), .flag_set(mset_v[k]), .pin(mat_out[k])
    );
    tmc_capture_chan #(.W(CNT_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .sig(cap_in[k]), .count(tc_q),
      .cfg(ccfg_q[3*k +: 3]), .flag_set(cset_v[k]), .cap_val(cap_val[k])
    );
  end

  assign set_vec  = {cset_v, mset_v};
  assign clr_mask = wr_flags ? bus_wdata[FW-1:0] : '0;
  assign irq      = |flags_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      clr_q   <= 1'b0;
      tc_q    <= '0;
      lim_q   <= '0;
      flags_q <= '0;
      mact_q  <= '0;
      ccfg_q  <= '0;
      ocfg_q  <= '0;
      for (int k = 0; k < N; k++) mreg_q[k] <= '0;
    end else begin
      if (|stop_v)      run_q <= 1'b0;
      else if (wr_ctrl) run_q <= bus_wdata[0];
      if (wr_ctrl)      clr_q <= bus_wdata[1];

      if (wr_count)     tc_q <= bus_wdata;
      else if (clr_q)   tc_q <= '0;
      else if (tick) begin
        if (|rst_v)       tc_q <= '0;
        else if (|stop_v) tc_q <= tc_q;
        else              tc_q <= tc_q + 1'b1;
      end

      flags_q <= (flags_q & ~clr_mask) | set_vec;
      if (wr_plim) lim_q  <= bus_wdata;
      if (wr_mact) mact_q <= bus_wdata[3*N-1:0];
      if (wr_ccfg) ccfg_q <= bus_wdata[3*N-1:0];
      if (wr_ocfg) ocfg_q <= bus_wdata[2*N-1:0];
      for (int k = 0; k < N; k++)
        if (bus_we && bus_addr == A_MBASE + TMC_AW'(k)) mreg_q[k] <= bus_wdata;
    end
  end

  assign sub = bus_addr[IW-1:0];

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL:  bus_rdata[1:0] = {clr_q, run_q};
      A_COUNT: bus_rdata = tc_q;
      A_PLIM:  bus_rdata = lim_q;
      A_PCNT:  bus_rdata = pcnt;
      A_FLAGS: bus_rdata[FW-1:0] = flags_q;
      A_MACT:  bus_rdata[3*N-1:0] = mact_q;
      A_CCFG:  bus_rdata[3*N-1:0] = ccfg_q;
      A_OCFG:  bus_rdata[FW+N-1:0] = {mat_out, ocfg_q};
      default: bus_rdata = (bus_addr >= A_CBASE) ? cap_val[sub] : mreg_q[sub];
    endcase
  end

  AST_CLR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_q && !wr_count) |=> (tc_q == '0)); // R3
  AST_MATCH_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    ((|rst_v) && !wr_count) |=> (tc_q == '0)); // R5
  AST_STOP_CLEARS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (|stop_v) |=> !run_q); // R6
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((flags_q & $past(set_vec)) == $past(set_vec))); // R10
  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !clr_q && !wr_count) |=> $stable(tc_q)); // R3
endmodule

// File: tb/test_tmr_match_capture.sv
`timescale 1ns/1ps
module test_tmr_match_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  cap_in = '0;
  logic [3:0]  mat_out;
  logic        irq;

  always #5 clk = ~clk;

  tmr_match_capture i_tmr_match_capture (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(cap_in),
    .mat_out(mat_out), .irq(irq)
  );

  int    checks = 0;
  int    errors = 0;
  bit    cmp_on = 0;
  string cur_req = "R1";
  logic [3:0] rot = '0;

  // behavioural reference model
  logic        m_run, m_clr;
  logic [31:0] m_tc, m_lim, m_pc;
  logic [7:0]  m_flags;
  logic [11:0] m_act, m_ccfg;
  logic [7:0]  m_ocfg;
  logic [3:0]  m_pin, m_prev;
  logic [31:0] m_mr [4];
  logic [31:0] m_cr [4];

  function automatic logic [31:0] m_read(input logic [3:0] a);
    case (a)
      4'd0: return {30'd0, m_clr, m_run};
      4'd1: return m_tc;
      4'd2: return m_lim;
      4'd3: return m_pc;
      4'd4: return {24'd0, m_flags};
      4'd5: return {20'd0, m_act};
      4'd6: return {20'd0, m_ccfg};
      4'd7: return {20'd0, m_pin, m_ocfg};
      default: return (a >= 4'd12) ? m_cr[a - 4'd12] : m_mr[a - 4'd8];
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_clr = 0; m_tc = 0; m_lim = 0; m_pc = 0; m_flags = 0;
      m_act = 0; m_ccfg = 0; m_ocfg = 0; m_pin = 0; m_prev = 0;
      for (int k = 0; k < 4; k++) begin m_mr[k] = 0; m_cr[k] = 0; end
    end else begin
      bit tk, any_rst, any_stop;
      logic [7:0] setb;
      logic [3:0] pin_n;
      logic [31:0] tc_old;
      tc_old = m_tc;
      tk = m_run && !m_clr && (m_pc == m_lim);
      any_rst = 0; any_stop = 0; setb = 0; pin_n = m_pin;
      for (int k = 0; k < 4; k++) begin
        if (tk && m_tc == m_mr[k]) begin
          if (m_act[3*k])   setb[k] = 1;
          if (m_act[3*k+1]) any_rst = 1;
          if (m_act[3*k+2]) any_stop = 1;
          case (m_ocfg[2*k +: 2])
            2'd1: pin_n[k] = 0;
            2'd2: pin_n[k] = 1;
            2'd3: pin_n[k] = ~m_pin[k];
            default: ;
          endcase
        end
        if ((m_ccfg[3*k] && cap_in[k] && !m_prev[k]) ||
            (m_ccfg[3*k+1] && !cap_in[k] && m_prev[k])) begin
          m_cr[k] = tc_old;
          if (m_ccfg[3*k+2]) setb[4+k] = 1;
        end
      end
      m_prev = cap_in;
      if (bus_we && bus_addr == 4'd3) m_pc = bus_wdata;
      else if (m_clr) m_pc = 0;
      else if (m_run) m_pc = tk ? 0 : m_pc + 1;
      if (bus_we && bus_addr == 4'd1) m_tc = bus_wdata;
      else if (m_clr) m_tc = 0;
      else if (tk) m_tc = any_rst ? 0 : (any_stop ? m_tc : m_tc + 1);
      if (any_stop) m_run = 0;
      else if (bus_we && bus_addr == 4'd0) m_run = bus_wdata[0];
      if (bus_we && bus_addr == 4'd0) m_clr = bus_wdata[1];
      m_flags = (m_flags & ~((bus_we && bus_addr == 4'd4) ? bus_wdata[7:0] : 8'd0)) | setb;
      if (bus_we && bus_addr == 4'd7) begin
        m_ocfg = bus_wdata[7:0];
        m_pin = bus_wdata[11:8];
      end else m_pin = pin_n;
      if (bus_we && bus_addr == 4'd2) m_lim = bus_wdata;
      if (bus_we && bus_addr == 4'd5) m_act = bus_wdata[11:0];
      if (bus_we && bus_addr == 4'd6) m_ccfg = bus_wdata[11:0];
      if (bus_we && bus_addr >= 4'd8 && bus_addr < 4'd12) m_mr[bus_addr - 4'd8] = bus_wdata;
    end
  end

  // compare every clock, after the edge has settled
  always @(posedge clk) begin
    #2;
    if (cmp_on) begin
      checks++;
      if (bus_rdata !== m_read(bus_addr)) begin
        errors++;
        $display("FAIL %s rdata addr %0d: actual %h expected %h", cur_req, bus_addr, bus_rdata, m_read(bus_addr));
      end
      checks++;
      if (mat_out !== m_pin) begin
        errors++;
        $display("FAIL R7 mat_out: actual %b expected %b", mat_out, m_pin);
      end
      checks++;
      if (irq !== (|m_flags)) begin
        errors++;
        $display("FAIL R4 irq: actual %b expected %b", irq, |m_flags);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bus_we = 0; bus_addr = rot; rot = rot + 1;
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_we = 0; bus_addr = a;
    @(posedge clk); #2; d = bus_rdata;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(posedge clk); #2; cmp_on = 1;
    // R1: reset state
    cur_req = "R1";
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), v); chk("R1 register zero after reset", v, 0);
    end
    chk("R1 pins low", {28'd0, mat_out}, 0);
    chk("R1 irq low", {31'd0, irq}, 0);

    // R11: loads and readback
    cur_req = "R11";
    wr(2, 2); wr(1, 5); wr(3, 1); wr(8, 6); wr(9, 3); wr(10, 12); wr(11, 10);
    rd(1, v); chk("R11 count load", v, 5);
    rd(2, v); chk("R11 prescale limit", v, 2);
    rd(3, v); chk("R11 prescale counter load", v, 1);
    rd(8, v); chk("R11 match0 value", v, 6);

    // R2: prescaled counting
    cur_req = "R2";
    wr(1, 0); wr(3, 0); wr(0, 1); idle(30); wr(0, 0);
    rd(1, v); chk("R2 count after prescaled run", v, m_read(1));

    // R3: clear-and-hold, then frozen
    cur_req = "R3";
    wr(0, 3); idle(5);
    rd(1, v); chk("R3 count held at zero", v, 0);
    rd(3, v); chk("R3 prescale held at zero", v, 0);
    wr(0, 0); idle(5);
    rd(1, v); chk("R3 count frozen when not running", v, 0);

    // R4 R5 R7: match actions and pin codes
    cur_req = "R5";
    wr(2, 1); wr(8, 6); wr(9, 3); wr(10, 2);
    wr(5, 32'h00B); wr(7, 32'hC1B);
    wr(0, 1); idle(60); wr(0, 0);
    chk("R4 irq raised", {31'd0, irq}, 1);
    rd(4, v); chk("R4 match flags 0 and 1", v & 32'h3, 3);
    chk("R7 code high on ch1", {31'd0, mat_out[1]}, 1);
    chk("R7 code low on ch2", {31'd0, mat_out[2]}, 0);
    chk("R7 code keep on ch3", {31'd0, mat_out[3]}, 1);
    rd(1, v); chk("R5 count never above reset point", {31'd0, v < 7}, 1);

    // R10: write-one-to-clear, plus clears colliding with sets
    cur_req = "R10";
    wr(4, 32'hFF);
    rd(4, v); chk("R10 flags cleared", v, 0);
    wr(2, 0); wr(5, 32'h003); wr(8, 3); wr(1, 0); wr(3, 0); wr(0, 1);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); bus_we = 1; bus_addr = 4; bus_wdata = 1;
    end
    wr(0, 0);
    rd(4, v); chk("R10 flags after colliding clears", v, m_read(4));

    // R12: one hit per count value under prescaling
    cur_req = "R12";
    wr(4, 32'hFF); wr(2, 3); wr(5, 32'h001); wr(8, 2); wr(7, 32'h003);
    wr(1, 0); wr(3, 0); wr(0, 1); idle(14); wr(0, 0);
    chk("R12 pin toggled exactly once", {31'd0, mat_out[0]}, 1);
    rd(4, v); chk("R12 flag set once", v & 32'h1, 1);

    // R6: stop, and stop combined with reset
    cur_req = "R6";
    wr(7, 0); wr(5, 32'h800); wr(11, 10); wr(2, 0); wr(1, 0); wr(3, 0); wr(0, 1);
    idle(20);
    rd(1, v); chk("R6 count stops on match value", v, 10);
    rd(0, v); chk("R6 run cleared by stop", v, 0);
    wr(5, 32'hC00); wr(11, 4); wr(1, 0); wr(0, 1); idle(12);
    rd(1, v); chk("R6 stop with reset leaves zero", v, 0);
    rd(0, v); chk("R6 run cleared by stop with reset", v, 0);

    // R8 R9: capture edges
    cur_req = "R8";
    wr(4, 32'hFF); wr(5, 0); wr(6, 32'h1D5); wr(1, 0); wr(0, 1);
    idle(3);
    @(negedge clk); cap_in = 4'b1111;
    idle(3);
    @(negedge clk); cap_in = 4'b0000;
    idle(3);
    @(negedge clk); cap_in = 4'b0101;
    idle(2);
    wr(0, 0);
    rd(15, v); chk("R8 unconfigured capture ignored", v, 0);
    rd(12, v); chk("R8 capture0 value", v, m_read(12));
    rd(13, v); chk("R8 capture1 falling-edge value", v, m_read(13));
    rd(4, v);  chk("R9 capture flags ch0 and ch2 only", (v >> 4) & 32'hF, 32'h5);
    chk("R9 irq from capture", {31'd0, irq}, 1);

    idle(4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule